// File: doc/BRIEF.md
# Audio serial clock generator

This block produces the bit clock and the two frame (left/right) clocks of an audio serial port from a faster master audio clock. In master operation it runs a programmable bit-clock divider. Two frame counters, one for transmit and one for receive, count bit periods from that divider. Each divider field is written as its ratio or count minus one. In slave operation the bit clock and both frame clocks arrive on input pins. They are synchronised to the master clock and passed through to the outputs.

The serializer and deserializer next to this block use two single-cycle strobes. One marks the launch edge of the bit clock and the other marks the sample edge. A polarity control inverts the bit clock on its pin. A two-bit sharing field either keeps the transmit and receive frame clocks independent or drives both of them from one side. A change to any divider field is held back until the next frame boundary, so that no short clock pulse is produced.

Top module: `audio_sclk_gen`

## Requirements
- R1: In master mode (`cfg_slave`=0, `cfg_bclk_inv`=0) with `cfg_bclk_div`=D, where D is at least 1, the bit clock has a period of D+1 master cycles. It is low for (D+1)/2 cycles, rounded down, and high for the remaining cycles. The low phase starts on a launch edge.
- R2: In master mode with `cfg_tx_frame`=M, the transmit frame clock lasts M+1 bit periods. It is low (left slot) for the first (M+1)/2 bit periods, rounded down, and high (right slot) for the rest. It changes only in a cycle where `launch_stb` is high.
- R3: The receive frame clock follows the rule of R2 using `cfg_rx_frame`, independently of the transmit length. The default lengths are 63, giving 32 low and 32 high bit periods.
- R4: `launch_stb` is high for exactly one cycle at each launch edge, which is the first cycle of the bit clock's low level in normal polarity. `sample_stb` is high for exactly one cycle at each sample edge, which is the first cycle of the high level. The two strobes are never high together.
- R5: With `cfg_bclk_inv`=1 the bit-clock pin is inverted: it is high while the launch strobe fires and low while the sample strobe fires. The strobe timing is unchanged.
- R6: In slave mode (`cfg_slave`=1), `bclk_out`, `tx_fclk_out` and `rx_fclk_out` equal the levels of `bclk_in`, `tx_fclk_in` and `rx_fclk_in` three master cycles earlier, whatever the polarity setting.
- R7: A new value of `cfg_bclk_div` or `cfg_tx_frame` takes effect at the next transmit frame boundary. A new value of `cfg_rx_frame` takes effect at the next receive frame boundary. The frame in progress completes with the old values.
- R8: `cfg_share` selects the frame-clock source. A value of 0 or 3 gives independent frame clocks. A value of 1 makes the receive frame clock copy the transmit frame clock. A value of 2 makes the transmit frame clock copy the receive frame clock.
- R9: While `rst_n` is low at a clock edge, in master mode with normal polarity, all outputs are low after that edge.
- R10: In slave mode the strobes follow the received bit clock. `launch_stb` is high in the cycle in which the synchronised clock makes its launch transition (a fall in normal polarity, a rise when inverted). `sample_stb` is high for the opposite transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_slave | input | 1 | 1: clocks come from pins; 0: block generates them |
| cfg_bclk_inv | input | 1 | 1: invert the bit-clock pin |
| cfg_share | input | 2 | Frame-clock sharing select (see R8) |
| cfg_bclk_div | input | 8 | Master-to-bit-clock ratio minus one |
| cfg_tx_frame | input | 8 | Transmit bit periods per frame minus one |
| cfg_rx_frame | input | 8 | Receive bit periods per frame minus one |
| bclk_in | input | 1 | Bit clock from the pin in slave mode |
| tx_fclk_in | input | 1 | Transmit frame clock from the pin in slave mode |
| rx_fclk_in | input | 1 | Receive frame clock from the pin in slave mode |
| bclk_out | output | 1 | Bit clock |
| tx_fclk_out | output | 1 | Transmit frame clock |
| rx_fclk_out | output | 1 | Receive frame clock |
| launch_stb | output | 1 | One-cycle strobe at each launch edge |
| sample_stb | output | 1 | One-cycle strobe at each sample edge |

## Verification
The assertions take three things for granted. First, the ratio field is nonzero whenever strobe exclusivity is checked, because a ratio of one cannot form a bit clock. Second, the mode and polarity inputs change only while reset is held. Third, the frame fields are at least one. The stimulus follows all three: every test reprograms the mode and polarity under reset, uses ratios of two or more and frame lengths of four or more, and changes divider fields only in the middle of a running frame, which is the case R7 is about. In slave mode the pin toggles are several master cycles apart, so the synchroniser sees every level.

// File: rtl/audio_clk_pkg.sv
// Package: shared types for the audio serial clock generator.
// Assumes nothing beyond a two-bit sharing field.
package audio_clk_pkg;

    // Frame-clock sharing selection
    typedef enum logic [1:0] {
        SHARE_NONE       = 2'd0,
        SHARE_RX_FROM_TX = 2'd1,
        SHARE_TX_FROM_RX = 2'd2,
        SHARE_NONE_ALT   = 2'd3
    } share_e;

    localparam int unsigned PIN_BCLK = 0;
    localparam int unsigned PIN_TXF  = 1;
    localparam int unsigned PIN_RXF  = 2;
    localparam int unsigned NUM_PINS = 3;

endpackage

// File: rtl/bclk_divider.sv
// Module: bclk_divider
// Divides the master clock into the bit clock in master mode.
// The ratio field is minus-one encoded. The active ratio is reloaded only
// when the counter wraps and the frame boundary input is high.
// The strobes are registered together with the clock, so each strobe is
// high in the first cycle of the new clock level.
// Assumes a ratio field of at least 1 (a ratio of 2 or more).
module bclk_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             reload,
    output logic             launch_next,
    output logic             bclk,
    output logic             launch_stb,
    output logic             sample_stb
);
    localparam int unsigned EXT_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q, n_q, cnt_nxt;
    logic [EXT_W-1:0] half;
    logic             raw_q;

    // Combinational: next count value and the rise point for the current ratio
    always_comb begin
        half        = ({1'b0, n_q} + EXT_W'(1)) >> 1;
        launch_next = run && (cnt_q == n_q);
        cnt_nxt     = (cnt_q == n_q) ? '0 : cnt_q + DIV_W'(1);
    end

    // Counter, clock level, strobes and active ratio
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q      <= '0;
            n_q        <= cfg_div;
            raw_q      <= 1'b0;
            launch_stb <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            cnt_q      <= cnt_nxt;
            raw_q      <= ({1'b0, cnt_nxt} >= half);
            launch_stb <= (cnt_q == n_q);
            sample_stb <= ({1'b0, cnt_nxt} == half) && (cnt_nxt != '0);
            if ((cnt_q == n_q) && reload) begin
                n_q <= cfg_div;
            end
        end
    end

    assign bclk = raw_q;

    // The launch strobe coincides with the low level
    p_launch_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && launch_stb |-> !bclk);
    // The sample strobe coincides with the high level
    p_sample_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && sample_stb |-> bclk);
    // The strobes never fire together for a valid ratio
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run && (n_q != '0) |-> !(launch_stb && sample_stb));
    // The ratio changes only at a frame boundary
    p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run && !(launch_next && reload) |=> $stable(n_q));
    // The clock level changes only together with a strobe
    p_edge_has_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && (bclk != $past(bclk)) |-> (launch_stb || sample_stb));

endmodule

// File: rtl/frame_divider.sv
// Module: frame_divider
// Counts bit periods in master mode and drives one frame clock. The clock
// is low for the first half of the frame and high for the second half.
// The length field is minus-one encoded and is reloaded only at the wrap.
// Assumes step is high for one cycle per bit period, on the launch edge.
module frame_divider #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             at_last,
    output logic             fclk
);
    localparam int unsigned EXT_W = LEN_W + 1;

    logic [LEN_W-1:0] bit_q, len_q, bit_nxt;
    logic [EXT_W-1:0] half_cur, half_new;

    // Combinational: half points for the active and the incoming length
    always_comb begin
        half_cur = ({1'b0, len_q}   + EXT_W'(1)) >> 1;
        half_new = ({1'b0, cfg_len} + EXT_W'(1)) >> 1;
        at_last  = (bit_q == len_q);
        bit_nxt  = bit_q + LEN_W'(1);
    end

    // Bit counter, frame clock and active length
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            bit_q <= '0;
            len_q <= cfg_len;
            fclk  <= 1'b0;
        end else if (step) begin
            if (at_last) begin
                bit_q <= '0;
                len_q <= cfg_len;
                fclk  <= (half_new == '0);
            end else begin
                bit_q <= bit_nxt;
                fclk  <= ({1'b0, bit_nxt} >= half_cur);
            end
        end
    end

    // The frame clock moves only on a launch step
    p_fclk_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && !step |=> $stable(fclk));
    // The length is held until the frame wraps
    p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run && !(step && at_last) |=> $stable(len_q));

endmodule

// File: rtl/slave_capture.sv
// Module: slave_capture
// Synchronises the externally supplied bit and frame clocks and derives the
// launch and sample strobes from the synchronised bit clock.
// Assumes the pins hold each level for at least two master cycles.
// The latency from pin to output is SYNC_STAGES+1 cycles.
module slave_capture
    import audio_clk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                inv,
    output logic                bclk_int,
    output logic                txf,
    output logic                rxf,
    output logic                launch_stb,
    output logic                sample_stb
);
    logic [NUM_PINS-1:0] synced;
    logic                next_int;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        // Synchroniser chain for one pin
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i[g]};
        end
        assign synced[g] = chain_q[SYNC_STAGES-1];
    end

    assign next_int = synced[PIN_BCLK] ^ inv;

    // Aligned output stage with edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_int   <= 1'b0;
            txf        <= 1'b0;
            rxf        <= 1'b0;
            launch_stb <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            bclk_int   <= next_int;
            txf        <= synced[PIN_TXF];
            rxf        <= synced[PIN_RXF];
            launch_stb <= bclk_int & ~next_int;
            sample_stb <= ~bclk_int & next_int;
        end
    end

    // A launch strobe follows a high-to-low move of the internal clock
    p_slave_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> !bclk_int && $past(bclk_int));
    // The strobes are mutually exclusive
    p_slave_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({launch_stb, sample_stb}));

endmodule

// File: rtl/audio_sclk_gen.sv
// Module: audio_sclk_gen (top)
// Audio serial clock generator. In master mode it drives the bit clock and
// the frame clocks. In slave mode it passes synchronised pin clocks through.
// Assumes the mode and polarity inputs change only while reset is held.
module audio_sclk_gen
    import audio_clk_pkg::*;
#(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned LEN_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_slave,
    input  logic             cfg_bclk_inv,
    input  logic [1:0]       cfg_share,
    input  logic [DIV_W-1:0] cfg_bclk_div,
    input  logic [LEN_W-1:0] cfg_tx_frame,
    input  logic [LEN_W-1:0] cfg_rx_frame,
    input  logic             bclk_in,
    input  logic             tx_fclk_in,
    input  logic             rx_fclk_in,
    output logic             bclk_out,
    output logic             tx_fclk_out,
    output logic             rx_fclk_out,
    output logic             launch_stb,
    output logic             sample_stb
);
    logic   run;
    logic   m_launch_next, m_bclk, m_launch, m_sample;
    logic   tx_last, rx_last, m_txf, m_rxf;
    logic   s_bclk, s_txf, s_rxf, s_launch, s_sample;
    logic   txf_src, rxf_src;
    share_e share;

    assign run   = !cfg_slave;
    assign share = share_e'(cfg_share);

    bclk_divider #(.DIV_W(DIV_W)) u_bclk (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cfg_div     (cfg_bclk_div),
        .reload      (tx_last),
        .launch_next (m_launch_next),
        .bclk        (m_bclk),
        .launch_stb  (m_launch),
        .sample_stb  (m_sample)
    );

    frame_divider #(.LEN_W(LEN_W)) u_txf (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (m_launch_next),
        .cfg_len (cfg_tx_frame),
        .at_last (tx_last),
        .fclk    (m_txf)
    );

    frame_divider #(.LEN_W(LEN_W)) u_rxf (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .step    (m_launch_next),
        .cfg_len (cfg_rx_frame),
        .at_last (rx_last),
        .fclk    (m_rxf)
    );

    slave_capture #(.SYNC_STAGES(SYNC_STAGES)) u_slv (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      ({rx_fclk_in, tx_fclk_in, bclk_in}),
        .inv        (cfg_bclk_inv),
        .bclk_int   (s_bclk),
        .txf        (s_txf),
        .rxf        (s_rxf),
        .launch_stb (s_launch),
        .sample_stb (s_sample)
    );

    // Output selection: mode, polarity and frame sharing
    always_comb begin
        txf_src    = cfg_slave ? s_txf : m_txf;
        rxf_src    = cfg_slave ? s_rxf : m_rxf;
        bclk_out   = (cfg_slave ? s_bclk : m_bclk) ^ cfg_bclk_inv;
        launch_stb = cfg_slave ? s_launch : m_launch;
        sample_stb = cfg_slave ? s_sample : m_sample;
        case (share)
            SHARE_RX_FROM_TX: begin tx_fclk_out = txf_src; rx_fclk_out = txf_src; end
            SHARE_TX_FROM_RX: begin tx_fclk_out = rxf_src; rx_fclk_out = rxf_src; end
            default:          begin tx_fclk_out = txf_src; rx_fclk_out = rxf_src; end
        endcase
    end

    // In master mode a receive frame wrap always coincides with a launch step
    p_rx_wrap_on_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && rx_last && !m_launch_next |=> $stable(m_rxf));

endmodule

// File: tb/sim_audio_sclk_gen.sv
module sim_audio_sclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_slave = 1'b0, cfg_bclk_inv = 1'b0;
    logic [1:0] cfg_share = 2'd0;
    logic [7:0] cfg_bclk_div = 8'd1, cfg_tx_frame = 8'd7, cfg_rx_frame = 8'd7;
    logic       bclk_in = 1'b0, tx_fclk_in = 1'b0, rx_fclk_in = 1'b0;
    logic       bclk_out, tx_fclk_out, rx_fclk_out, launch_stb, sample_stb;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    audio_sclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_share(cfg_share), .cfg_bclk_div(cfg_bclk_div), .cfg_tx_frame(cfg_tx_frame),
        .cfg_rx_frame(cfg_rx_frame), .bclk_in(bclk_in), .tx_fclk_in(tx_fclk_in),
        .rx_fclk_in(rx_fclk_in), .bclk_out(bclk_out), .tx_fclk_out(tx_fclk_out),
        .rx_fclk_out(rx_fclk_out), .launch_stb(launch_stb), .sample_stb(sample_stb)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int div, input int txl, input int rxl,
                            input bit slv, input bit inv, input int shr);
        step();
        rst_n = 1'b0;
        cfg_bclk_div = 8'(div); cfg_tx_frame = 8'(txl); cfg_rx_frame = 8'(rxl);
        cfg_slave = slv; cfg_bclk_inv = inv; cfg_share = 2'(shr);
        bclk_in = 1'b0; tx_fclk_in = 1'b0; rx_fclk_in = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    function automatic logic fclk_of(input bit rx);
        return rx ? rx_fclk_out : tx_fclk_out;
    endfunction

    // Measures one bit period starting at a launch edge
    task automatic measure_bclk(input string req, input int exp_lo, input int exp_hi,
                                input logic idle);
        int lo = 0, hi = 0;
        logic saw_sample;
        while (!launch_stb) step();
        while (bclk_out == idle) begin lo++; step(); end
        saw_sample = sample_stb;
        while (bclk_out != idle) begin hi++; step(); end
        chk({req, " low cycles"}, lo, exp_lo);
        chk({req, " high cycles"}, hi, exp_hi);
        chk({req, " sample strobe at sample edge"}, int'(saw_sample), 1);
        chk({req, " launch strobe at launch edge"}, int'(launch_stb), 1);
    endtask

    task automatic count_phase(input bit rx, input logic lvl, output int n);
        n = 0;
        while (fclk_of(rx) == lvl) begin
            if (launch_stb) n++;
            step();
        end
    endtask

    task automatic measure_frame(input string req, input bit rx, input int exp_lo,
                                 input int exp_hi);
        int lo, hi;
        while (fclk_of(rx) != 1'b1) step();
        while (fclk_of(rx) != 1'b0) step();
        count_phase(rx, 1'b0, lo);
        count_phase(rx, 1'b1, hi);
        chk({req, " left bit periods"}, lo, exp_lo);
        chk({req, " right bit periods"}, hi, exp_hi);
    endtask

    // R9: reset state
    task automatic t_reset();
        step();
        rst_n = 1'b0; cfg_slave = 1'b0; cfg_bclk_inv = 1'b0; cfg_share = 2'd0;
        repeat (3) step();
        chk("R9 bclk_out", int'(bclk_out), 0);
        chk("R9 tx_fclk_out", int'(tx_fclk_out), 0);
        chk("R9 rx_fclk_out", int'(rx_fclk_out), 0);
        chk("R9 strobes", int'({launch_stb, sample_stb}), 0);
        rst_n = 1'b1;
    endtask

    // R1/R4: bit clock shape for several ratios
    task automatic t_bclk();
        do_reset(3, 7, 7, 0, 0, 0); measure_bclk("R1 R4 ratio4", 2, 2, 1'b0);
        do_reset(4, 7, 7, 0, 0, 0); measure_bclk("R1 R4 ratio5", 2, 3, 1'b0);
        do_reset(1, 7, 7, 0, 0, 0); measure_bclk("R1 R4 ratio2", 1, 1, 1'b0);
    endtask

    // R2/R3: frame clock shapes
    task automatic t_frames();
        do_reset(1, 63, 63, 0, 0, 0);
        measure_frame("R3 default rx", 1'b1, 32, 32);
        measure_frame("R2 default tx", 1'b0, 32, 32);
        do_reset(1, 4, 9, 0, 0, 0);
        measure_frame("R2 odd tx", 1'b0, 2, 3);
        measure_frame("R3 independent rx", 1'b1, 5, 5);
    endtask

    // R5: polarity inversion
    task automatic t_invert();
        do_reset(3, 7, 7, 0, 1, 0);
        measure_bclk("R5 inverted", 2, 2, 1'b1);
    endtask

    // R7: changes wait for the frame boundary
    task automatic t_change();
        int n;
        do_reset(1, 7, 7, 0, 0, 0);
        while (tx_fclk_out != 1'b0) step();
        while (tx_fclk_out != 1'b1) step();
        cfg_bclk_div = 8'd3;
        measure_bclk("R7 old ratio kept", 1, 1, 1'b0);
        while (tx_fclk_out != 1'b0) step();
        measure_bclk("R7 new ratio at boundary", 2, 2, 1'b0);
        do_reset(1, 7, 7, 0, 0, 0);
        while (tx_fclk_out != 1'b0) step();
        while (tx_fclk_out != 1'b1) step();
        cfg_tx_frame = 8'd3;
        count_phase(1'b0, 1'b1, n);
        chk("R7 old frame length kept", n, 4);
        count_phase(1'b0, 1'b0, n);
        chk("R7 new length left half", n, 2);
        count_phase(1'b0, 1'b1, n);
        chk("R7 new length right half", n, 2);
    endtask

    // R8: frame clock sharing
    task automatic t_share();
        int bad = 0;
        do_reset(1, 7, 3, 0, 0, 1);
        for (int i = 0; i < 100; i++) begin
            if (rx_fclk_out !== tx_fclk_out) bad++;
            step();
        end
        chk("R8 rx copies tx mismatches", bad, 0);
        measure_frame("R8 rx copies tx shape", 1'b1, 4, 4);
        cfg_share = 2'd2; bad = 0;
        for (int i = 0; i < 100; i++) begin
            if (rx_fclk_out !== tx_fclk_out) bad++;
            step();
        end
        chk("R8 tx copies rx mismatches", bad, 0);
        measure_frame("R8 tx copies rx shape", 1'b0, 2, 2);
        cfg_share = 2'd3;
        measure_frame("R8 code3 tx independent", 1'b0, 4, 4);
        measure_frame("R8 code3 rx independent", 1'b1, 2, 2);
    endtask

    // R6/R10: slave pass-through and strobes
    task automatic t_slave(input bit inv);
        int bad_b = 0, bad_t = 0, bad_r = 0, bad_l = 0, bad_s = 0;
        logic [2:0] hb = '0, ht = '0, hr = '0;
        logic prev;
        do_reset(1, 7, 7, 1, inv, 0);
        step();
        prev = bclk_out;
        for (int i = 0; i < 240; i++) begin
            if (i >= 3) begin
                if (bclk_out !== hb[2]) bad_b++;
                if (tx_fclk_out !== ht[2]) bad_t++;
                if (rx_fclk_out !== hr[2]) bad_r++;
                if (launch_stb !== ((prev != bclk_out) && (bclk_out == inv))) bad_l++;
                if (sample_stb !== ((prev != bclk_out) && (bclk_out != inv))) bad_s++;
            end
            prev = bclk_out;
            if (i % 3 == 0)  bclk_in = ~bclk_in;
            if (i % 24 == 0) tx_fclk_in = ~tx_fclk_in;
            if (i % 12 == 0) rx_fclk_in = ~rx_fclk_in;
            hb = {hb[1:0], bclk_in}; ht = {ht[1:0], tx_fclk_in}; hr = {hr[1:0], rx_fclk_in};
            step();
        end
        chk(inv ? "R6 bclk follows pin inverted mode" : "R6 bclk follows pin", bad_b, 0);
        chk("R6 tx frame follows pin", bad_t, 0);
        chk("R6 rx frame follows pin", bad_r, 0);
        chk(inv ? "R10 launch on rise when inverted" : "R10 launch on fall", bad_l, 0);
        chk("R10 sample strobe", bad_s, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_bclk();
        t_frames();
        t_invert();
        t_change();
        t_share();
        t_slave(1'b0);
        t_slave(1'b1);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule